// File: doc/BRIEF.md
# Compressed Audio Burst Detector

This block watches the stream of 16-bit audio data words recovered from a digital audio receiver. It decides whether the stream carries a compressed (non-PCM) payload or a DTS-CD stream instead of plain PCM samples. Each strobed word is fed to two recognisers.

The first recogniser is a burst preamble matcher. It looks for the two-word sync pair 0xF872 then 0x4E1F and then takes the next two words as the burst-info word and the length word. The second recogniser is a DTS-CD sync recogniser that compares each word with the word before it. It covers a 16-bit form and a 14-bit form, and each form can be enabled on its own.

Each recogniser drives a flag that stays set while syncs keep arriving and drops after a fixed number of frames with no sync. An auto-detect output combines the two flags for downstream muting logic. When the receiver loses lock, the block returns to its initial state.

Top module: `nonpcm_burst_detect`

## Requirements
- R1: After reset, `nonPcm`, `dtsCd`, `autoDet` and `newBurst` are 0, and `burstInfo` and `burstLen` are 0x0000.
- R2: A strobed word 0xF872 followed by the next strobed word 0x4E1F is a burst sync. It sets `nonPcm` at the clock edge that samples 0x4E1F. After 0xF872, a repeated 0xF872 keeps the matcher waiting for 0x4E1F, and any other word makes it start over.
- R3: After a burst sync, the next strobed word is the burst-info candidate and the strobed word after that is the length word. Both are loaded into `burstInfo` and `burstLen` together, at the edge that samples the length word. They are never loaded from an incomplete sequence.
- R4: `newBurst` is high for exactly one clock cycle. That cycle follows the edge at which `burstInfo` and `burstLen` are loaded.
- R5: When `dtsEn16` is 1, a strobed word 0x7FFE followed by the strobed word 0x8001 sets `dtsCd`. When `dtsEn16` is 0, this pair has no effect on `dtsCd`.
- R6: When `dtsEn14` is 1, a strobed word whose low 14 bits are 0x1FFF followed by a strobed word whose low 14 bits are 0x2800 sets `dtsCd`; the upper two bits are ignored, so 0xE800 qualifies. When `dtsEn14` is 0, this pair has no effect on `dtsCd`.
- R7: `autoDet` equals the OR of `nonPcm` and `dtsCd`.
- R8: A flag that is set stays at 1 through 4095 further strobed words that carry no sync of its kind. It clears at the 4096th such word. A new sync of its kind restarts this count.
- R9: A word presented while `wordValid` is 0 is ignored by both recognisers.
- R10: While `locked` is 0, the block returns at the next clock edge to the R1 state. It also abandons any partly matched preamble or DTS pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordValid | input | 1 | One-cycle strobe marking a new frame data word |
| dataWord | input | 16 | Data word of the frame |
| locked | input | 1 | Receiver lock indication; 0 resets the detector state |
| dtsEn14 | input | 1 | Enable for the 14-bit DTS-CD sync form |
| dtsEn16 | input | 1 | Enable for the 16-bit DTS-CD sync form |
| nonPcm | output | 1 | Compressed burst stream present |
| dtsCd | output | 1 | DTS-CD stream present |
| autoDet | output | 1 | OR of nonPcm and dtsCd |
| burstInfo | output | 16 | Last captured burst-info word |
| burstLen | output | 16 | Last captured length word |
| newBurst | output | 1 | One-cycle pulse when a new burst header is captured |

## Verification
A matcher stuck in a wrong state shows at the ports within one or two strobed words. Either `nonPcm` fails to rise on the sync word, or `newBurst` and the captured words appear at the wrong word or not at all. A wrong frame count in a watchdog only shows at the end of the hold window, so the bench counts out exactly 4095 and 4096 sync-free words and samples the flag at both points. Faults in the lock-loss clearing and in the per-form enables are exposed by following those events with words that would complete a stale partial match.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam int WORD_W = 16;

  localparam logic [WORD_W-1:0] SYNC_A_WORD = 16'hF872;
  localparam logic [WORD_W-1:0] SYNC_B_WORD = 16'h4E1F;
  localparam logic [WORD_W-1:0] DTS16_FIRST = 16'h7FFE;
  localparam logic [WORD_W-1:0] DTS16_SECOND = 16'h8001;
  localparam logic [13:0] DTS14_FIRST = 14'h1FFF;
  localparam logic [13:0] DTS14_SECOND = 14'h2800;

  localparam int NUM_DETECTORS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAW_A,
    ST_SAW_B,
    ST_SAW_INFO
  } matchState_t;

  typedef struct packed {
    logic syncHit;
    logic holdInfo;
    logic commitBurst;
    logic flush;
  } ctrlStrobe_t;
endpackage

// File: rtl/bd_watchdog.sv
module bd_watchdog #(
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic flush,
  input  logic tick,
  input  logic restart,
  output logic flag
);
  localparam int CNT_W = (TIMEOUT_FRAMES > 2) ? $clog2(TIMEOUT_FRAMES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_FRAMES - 1);

  logic [CNT_W-1:0] idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag    <= 1'b0;
      idleCnt <= '0;
    end else if (flush) begin
      flag    <= 1'b0;
      idleCnt <= '0;
    end else if (tick && restart) begin
      flag    <= 1'b1;
      idleCnt <= '0;
    end else if (tick && flag) begin
      if (idleCnt == LAST_CNT) begin
        flag    <= 1'b0;
        idleCnt <= '0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bd_ctrl.sv
module bd_ctrl
  import bd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wordValid,
  input  logic        locked,
  input  logic        isSyncA,
  input  logic        isSyncB,
  output ctrlStrobe_t strb
);
  matchState_t state, stateNext;
  logic take;

  assign take = wordValid && locked;

  always_comb begin
    stateNext = state;
    strb      = '0;
    strb.flush = !locked;
    if (!locked) begin
      stateNext = ST_IDLE;
    end else if (take) begin
      unique case (state)
        ST_IDLE: stateNext = isSyncA ? ST_SAW_A : ST_IDLE;
        ST_SAW_A: begin
          if (isSyncB) begin
            stateNext    = ST_SAW_B;
            strb.syncHit = 1'b1;
          end else if (isSyncA) begin
            stateNext = ST_SAW_A;
          end else begin
            stateNext = ST_IDLE;
          end
        end
        ST_SAW_B: begin
          stateNext     = ST_SAW_INFO;
          strb.holdInfo = 1'b1;
        end
        ST_SAW_INFO: begin
          stateNext        = ST_IDLE;
          strb.commitBurst = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/bd_datapath.sv
module bd_datapath
  import bd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wordValid,
  input  logic [WORD_W-1:0]        dataWord,
  input  logic                     dtsEn14,
  input  logic                     dtsEn16,
  input  ctrlStrobe_t              strb,
  output logic                     isSyncA,
  output logic                     isSyncB,
  output logic [NUM_DETECTORS-1:0] syncEvents,
  output logic [WORD_W-1:0]        burstInfo,
  output logic [WORD_W-1:0]        burstLen,
  output logic                     newBurst
);
  logic [WORD_W-1:0] prevWord;
  logic              prevValid;
  logic [WORD_W-1:0] infoHold;
  logic              hit16;
  logic              hit14;
  logic              dtsHit;

  assign isSyncA = (dataWord == SYNC_A_WORD);
  assign isSyncB = (dataWord == SYNC_B_WORD);

  assign hit16 = dtsEn16 && (prevWord == DTS16_FIRST) && (dataWord == DTS16_SECOND);
  assign hit14 = dtsEn14 && (prevWord[13:0] == DTS14_FIRST) && (dataWord[13:0] == DTS14_SECOND);
  assign dtsHit = wordValid && !strb.flush && prevValid && (hit16 || hit14);

  assign syncEvents = {dtsHit, strb.syncHit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord  <= '0;
      prevValid <= 1'b0;
    end else if (strb.flush) begin
      prevWord  <= '0;
      prevValid <= 1'b0;
    end else if (wordValid) begin
      prevWord  <= dataWord;
      prevValid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      infoHold  <= '0;
      burstInfo <= '0;
      burstLen  <= '0;
      newBurst  <= 1'b0;
    end else if (strb.flush) begin
      infoHold  <= '0;
      burstInfo <= '0;
      burstLen  <= '0;
      newBurst  <= 1'b0;
    end else begin
      newBurst <= strb.commitBurst;
      if (strb.holdInfo) infoHold <= dataWord;
      if (strb.commitBurst) begin
        burstInfo <= infoHold;
        burstLen  <= dataWord;
      end
    end
  end
endmodule

// File: rtl/nonpcm_burst_detect.sv
module nonpcm_burst_detect
  import bd_pkg::*;
#(
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [15:0]       dataWord,
  input  logic              locked,
  input  logic              dtsEn14,
  input  logic              dtsEn16,
  output logic              nonPcm,
  output logic              dtsCd,
  output logic              autoDet,
  output logic [15:0]       burstInfo,
  output logic [15:0]       burstLen,
  output logic              newBurst
);
  ctrlStrobe_t              strb;
  logic                     isSyncA;
  logic                     isSyncB;
  logic [NUM_DETECTORS-1:0] syncEvents;
  logic [NUM_DETECTORS-1:0] flags;

  bd_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .locked    (locked),
    .isSyncA   (isSyncA),
    .isSyncB   (isSyncB),
    .strb      (strb)
  );

  bd_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .wordValid  (wordValid),
    .dataWord   (dataWord),
    .dtsEn14    (dtsEn14),
    .dtsEn16    (dtsEn16),
    .strb       (strb),
    .isSyncA    (isSyncA),
    .isSyncB    (isSyncB),
    .syncEvents (syncEvents),
    .burstInfo  (burstInfo),
    .burstLen   (burstLen),
    .newBurst   (newBurst)
  );

  for (genvar g = 0; g < NUM_DETECTORS; g++) begin : gen_wd
    bd_watchdog #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) wd_i (
      .clk     (clk),
      .rstN    (rstN),
      .flush   (strb.flush),
      .tick    (wordValid),
      .restart (syncEvents[g]),
      .flag    (flags[g])
    );
  end

  assign nonPcm  = flags[0];
  assign dtsCd   = flags[1];
  assign autoDet = |flags;
endmodule

// File: rtl/bd_checks.sv
module bd_checks (
  input logic        clk,
  input logic        rstN,
  input logic        wordValid,
  input logic [15:0] dataWord,
  input logic        locked,
  input logic        nonPcm,
  input logic        dtsCd,
  input logic [15:0] burstInfo,
  input logic [15:0] burstLen,
  input logic        newBurst
);
  // R4: a capture pulse only follows a strobed word taken while locked
  a_r4_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    newBurst |-> $past(wordValid && locked));

  // R4: the pulse never lasts two cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    newBurst |=> !newBurst);

  // R10: lock loss clears everything at the next edge
  a_r10_lock_clear: assert property (@(posedge clk) disable iff (!rstN)
    !locked |=> (!nonPcm && !dtsCd && burstInfo == 16'h0 && burstLen == 16'h0 && !newBurst));

  // R2: the burst flag rises only on the second sync word
  a_r2_rise_on_sync: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nonPcm) |-> ($past(wordValid) && $past(dataWord) == 16'h4E1F));

  // R9: no strobe means no change to the captured words
  a_r9_hold_captures: assert property (@(posedge clk) disable iff (!rstN)
    (!wordValid && locked) |=> ($stable(burstInfo) && $stable(burstLen)));

  // R5: the DTS flag rises only on a strobed word
  a_r5_dts_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dtsCd) |-> $past(wordValid && locked));
endmodule

bind nonpcm_burst_detect bd_checks chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .wordValid (wordValid),
  .dataWord  (dataWord),
  .locked    (locked),
  .nonPcm    (nonPcm),
  .dtsCd     (dtsCd),
  .burstInfo (burstInfo),
  .burstLen  (burstLen),
  .newBurst  (newBurst)
);

// File: tb/nonpcm_burst_detect_tb_top.sv
module nonpcm_burst_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC = 8;
  localparam int MAX_CYCLES = 200000;

  // {word, expNonPcm, expDtsCd, expAutoDet, expNewBurst}
  localparam logic [19:0] VEC [0:NUM_VEC-1] = '{
    {16'h1234, 4'b0000},
    {16'hF872, 4'b0000},
    {16'hF872, 4'b0000},
    {16'h4E1F, 4'b1010},
    {16'h0015, 4'b1010},
    {16'h0800, 4'b1011},
    {16'h7FFE, 4'b1010},
    {16'h8001, 4'b1110}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] dataWord = 16'h0;
  logic        locked = 1'b1;
  logic        dtsEn14 = 1'b1;
  logic        dtsEn16 = 1'b1;
  logic        nonPcm, dtsCd, autoDet, newBurst;
  logic [15:0] burstInfo, burstLen;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nonpcm_burst_detect dut_i (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .dataWord(dataWord),
    .locked(locked), .dtsEn14(dtsEn14), .dtsEn16(dtsEn16),
    .nonPcm(nonPcm), .dtsCd(dtsCd), .autoDet(autoDet),
    .burstInfo(burstInfo), .burstLen(burstLen), .newBurst(newBurst)
  );

  task automatic checkEq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [15:0] w);
    @(negedge clk);
    dataWord  = w;
    wordValid = 1'b1;
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic checkFlags(input string tag, input logic n, input logic d);
    checkEq({tag, " nonPcm"}, {15'h0, nonPcm}, {15'h0, n});
    checkEq({tag, " dtsCd"}, {15'h0, dtsCd}, {15'h0, d});
    checkEq({tag, " R7 autoDet"}, {15'h0, autoDet}, {15'h0, n | d});
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkFlags("R1 reset", 1'b0, 1'b0);
    checkEq("R1 burstInfo", burstInfo, 16'h0);
    checkEq("R1 burstLen", burstLen, 16'h0);
    checkEq("R1 newBurst", {15'h0, newBurst}, 16'h0);

    // R9: unstrobed sync-A word is ignored, so the strobed sync-B does not match
    @(negedge clk);
    dataWord = 16'hF872;
    @(negedge clk);
    sendWord(16'h4E1F);
    checkFlags("R9 unstrobed word", 1'b0, 1'b0);

    // Vector table: R2 R3 R4 R5 R7
    for (int i = 0; i < NUM_VEC; i++) begin
      sendWord(VEC[i][19:4]);
      checkEq($sformatf("R2 vec%0d nonPcm", i), {15'h0, nonPcm}, {15'h0, VEC[i][3]});
      checkEq($sformatf("R5 vec%0d dtsCd", i), {15'h0, dtsCd}, {15'h0, VEC[i][2]});
      checkEq($sformatf("R7 vec%0d autoDet", i), {15'h0, autoDet}, {15'h0, VEC[i][1]});
      checkEq($sformatf("R4 vec%0d newBurst", i), {15'h0, newBurst}, {15'h0, VEC[i][0]});
      if (i == 5) begin
        @(negedge clk);
        checkEq("R4 pulse one cycle", {15'h0, newBurst}, 16'h0);
      end
    end
    checkEq("R3 burstInfo", burstInfo, 16'h0015);
    checkEq("R3 burstLen", burstLen, 16'h0800);

    // R3: broken and incomplete sequences leave the captures unchanged
    sendWord(16'hF872);
    sendWord(16'h1111);
    sendWord(16'h2222);
    sendWord(16'h3333);
    checkEq("R3 broken keeps info", burstInfo, 16'h0015);
    checkEq("R3 broken keeps len", burstLen, 16'h0800);
    sendWord(16'hF872);
    sendWord(16'h4E1F);
    sendWord(16'h0033);
    checkEq("R3 partial keeps len", burstLen, 16'h0800);

    // R10: lock loss mid-sequence
    @(negedge clk);
    locked = 1'b0;
    @(negedge clk);
    locked = 1'b1;
    checkFlags("R10 lock loss", 1'b0, 1'b0);
    checkEq("R10 burstInfo", burstInfo, 16'h0);
    checkEq("R10 burstLen", burstLen, 16'h0);
    sendWord(16'h0044);
    checkEq("R10 abandoned newBurst", {15'h0, newBurst}, 16'h0);
    checkEq("R10 abandoned burstLen", burstLen, 16'h0);

    // R5 R6: enables off
    dtsEn14 = 1'b0;
    dtsEn16 = 1'b0;
    sendWord(16'h7FFE);
    sendWord(16'h8001);
    checkFlags("R5 16-bit disabled", 1'b0, 1'b0);
    sendWord(16'h1FFF);
    sendWord(16'h2800);
    checkFlags("R6 14-bit disabled", 1'b0, 1'b0);
    // R6: 14-bit form with upper bits differing
    dtsEn14 = 1'b1;
    sendWord(16'hDFFF);
    sendWord(16'hE800);
    checkFlags("R6 14-bit enabled", 1'b0, 1'b1);

    // R8: watchdog window for the burst flag
    @(negedge clk);
    locked = 1'b0;
    @(negedge clk);
    locked = 1'b1;
    sendWord(16'hF872);
    sendWord(16'h4E1F);
    for (int k = 0; k < 4095; k++) sendWord(16'h0000);
    checkFlags("R8 after 4095", 1'b1, 1'b0);
    sendWord(16'h0000);
    checkFlags("R8 after 4096", 1'b0, 1'b0);

    // R8: restart extends the window
    sendWord(16'hF872);
    sendWord(16'h4E1F);
    for (int k = 0; k < 3000; k++) sendWord(16'h0000);
    sendWord(16'hF872);
    sendWord(16'h4E1F);
    for (int k = 0; k < 3000; k++) sendWord(16'h0000);
    checkFlags("R8 restarted", 1'b1, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule